// File: doc/BRIEF.md
# Timebase Interval Timer with Interrupt Request

This block is a free-running up-counter that advances once on each clock cycle in which the count-enable input `tick` is high. A two-bit interval select picks one counter bit as the interval tap. When that bit falls from 1 to 0 as the counter steps, a sticky overflow flag is set. The interrupt request output is a plain level, high whenever the flag and the interrupt enable are both 1.

Software reaches the block through a single five-bit control word. One write sets the interval select and the interrupt enable. The same write can clear the flag by writing 0 to its position, and can clear the counter by writing 0 to the strobe position. Writing 1 to either of these two positions has no effect, so a handler can enable interrupts and discard a stale flag in one operation. The control word reads back at all times, and the strobe position always reads 1.

Top module: `tbi_timer`

## Requirements
- R1: The counter increases by one on each clock edge where `tick` is 1 and no counter clear is written. It holds its value when `tick` is 0.
- R2: Control bits [1:0] hold `sel`. The tap is bit TAP_BASE + TAP_STEP*sel, which is 11, 13, 15 or 17 by default. From a cleared counter, the flag sets on the 2^(tap+1)-th tick, which is the tick where the tap bit falls.
- R3: The flag (control bit 3) is set by a tap fall whatever the interrupt enable (control bit 2) holds.
- R4: `irq` is 1 exactly when the flag and the enable are both 1.
- R5: A write with bit 3 equal to 0 clears the flag. A write with bit 3 equal to 1 leaves the flag as it is.
- R6: A write that turns the enable from 0 to 1 while the flag is 1 raises `irq` right after that write edge, with no new overflow needed.
- R7: A single write with bit 2 equal to 1 and bit 3 equal to 0 turns on the enable and clears the flag, and `irq` stays 0.
- R8: A write with bit 4 equal to 0 clears the counter. If that write lands on the same edge as a tap fall, the counter is cleared and the flag is not set.
- R9: A tap fall on the same edge as a software flag clear leaves the flag at 1.
- R10: After reset the counter, the flag, the enable and the select are 0. Control bit 4 always reads back as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for the counter |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 5 | Control write value: [1:0] select, [2] enable, [3] flag (0 clears), [4] counter clear (0 clears) |
| rd_data | output | 5 | Control read value, same layout, bit 4 fixed at 1 |
| irq | output | 1 | Level interrupt request |

## Verification
Every result of a write or a tick appears on the first clock edge that samples it. The counter, the flag and the enable are single registers, and `irq` and `rd_data` are combinational from them. The bench changes inputs at the falling edge and reads outputs at the next falling edge, one rising edge later. Interval checks count tick edges from a counter clear and expect the flag on exactly the 2^(tap+1)-th tick. A gated-tick run expects it on edge 2^(tap+1)*2-1. The collision cases place the write on the very edge that carries the tap fall, and then read the flag at the next falling edge.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
  localparam int SEL_W  = 2;
  localparam int REG_W  = 5;
  localparam int F_SEL  = 0;
  localparam int F_IE   = 2;
  localparam int F_FLAG = 3;
  localparam int F_CLR  = 4;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
  } tbi_cfg_t;
endpackage

// File: rtl/tbi_ctrl.sv
module tbi_ctrl
  import tbi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output tbi_cfg_t         cfg,
  output logic             sw_flag_clr,
  output logic             sw_cnt_clr
);
  // Zero written into the flag or strobe position acts; a one is ignored.
  assign sw_flag_clr = wr_en && !wr_data[F_FLAG];
  assign sw_cnt_clr  = wr_en && !wr_data[F_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.sel <= wr_data[F_SEL +: SEL_W];
      cfg.ie  <= wr_data[F_IE];
    end
  end

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg.sel == $past(wr_data[F_SEL +: SEL_W])) && (cfg.ie == $past(wr_data[F_IE])));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/tbi_counter.sv
module tbi_counter
  import tbi_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int TAP_BASE = 11,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             tap_fall
);
  localparam int TAP_MAX = TAP_BASE + TAP_STEP * ((1 << SEL_W) - 1);

  // Bit position chosen by the interval select.
  function automatic int tap_pos(input logic [SEL_W-1:0] s);
    return TAP_BASE + TAP_STEP * int'(s);
  endfunction

  // Mask of bits 0..p. An increment drops bit p exactly when all of them are 1.
  function automatic logic [CNT_W-1:0] low_mask(input int p);
    logic [CNT_W-1:0] one;
    one = 1;
    return (one << (p + 1)) - one;
  endfunction

  logic [CNT_W-1:0] mask;
  assign mask     = low_mask(tap_pos(sel));
  assign tap_fall = tick && !clr && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  initial begin
    if (TAP_MAX >= CNT_W) $error("tap position %0d exceeds counter width %0d", TAP_MAX, CNT_W);
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> cnt == $past(cnt));
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  p_tap_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_fall |=> !cnt[tap_pos($past(sel))]);
endmodule

// File: rtl/tbi_flag.sv
module tbi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic flag
);
  // A hardware set outranks a software clear on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (hw_set) flag <= 1'b1;
    else if (sw_clr) flag <= 1'b0;
  end

  p_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set && sw_clr |=> flag);
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hw_set));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr && !hw_set |=> !flag);
endmodule

// File: rtl/tbi_timer.sv
module tbi_timer
  import tbi_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int TAP_BASE = 11,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  tbi_cfg_t         cfg;
  logic             sw_flag_clr;
  logic             sw_cnt_clr;
  logic             tap_fall;
  logic             flag;
  logic [CNT_W-1:0] cnt;

  tbi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .sw_flag_clr(sw_flag_clr), .sw_cnt_clr(sw_cnt_clr)
  );

  tbi_counter #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(sw_cnt_clr), .sel(cfg.sel),
    .cnt(cnt), .tap_fall(tap_fall)
  );

  tbi_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hw_set(tap_fall), .sw_clr(sw_flag_clr), .flag(flag)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[F_SEL +: SEL_W]    = cfg.sel;
    rd_data[F_IE]              = cfg.ie;
    rd_data[F_FLAG]            = flag;
    rd_data[F_CLR]             = 1'b1;
  end

  assign irq = flag && cfg.ie;

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[F_IE] && wr_data[F_FLAG] && flag |=> irq);
  p_combo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[F_IE] && !wr_data[F_FLAG] && !tap_fall |=> !irq);
  p_clr_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cnt_clr |=> !$rose(flag));
  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag && cfg.ie && !sw_flag_clr && !(wr_en && !wr_data[F_IE]) |=> irq);
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[F_CLR]);
endmodule

// File: tb/sim_tbi_timer.sv
module sim_tbi_timer;
  localparam int CW = 8;
  localparam int TB = 1;
  localparam int TS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbi_timer #(.CNT_W(CW), .TAP_BASE(TB), .TAP_STEP(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Word layout: {clr_n, flag, ie, sel[1:0]}
  function automatic logic [4:0] word(input bit clr_n, input bit fl, input bit ie, input int sel);
    return {clr_n, fl, ie, 2'(sel)};
  endfunction

  task automatic wr(input logic [4:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset readback", rd_data, 5'b10000);
    check("R10 reset irq", irq, 0);
  endtask

  task automatic t_flag_no_ie();
    tick = 1'b1;
    repeat (3) step();
    check("R3 flag before tap fall", rd_data[3], 0);
    step();
    check("R3 flag set with ie=0", rd_data[3], 1);
    check("R4 irq low with ie=0", irq, 0);
    tick = 1'b0;
  endtask

  task automatic t_wake();
    wr(word(1, 1, 1, 0));
    check("R6 irq on enable over pending flag", irq, 1);
    check("R5 writing one keeps flag", rd_data[3], 1);
  endtask

  task automatic t_clear_flag();
    wr(word(1, 0, 1, 0));
    check("R5 flag cleared by zero", rd_data[3], 0);
    check("R4 irq low after clear", irq, 0);
  endtask

  task automatic t_combo();
    wr(word(0, 0, 0, 0));
    tick = 1'b1;
    repeat (4) step();
    tick = 1'b0;
    check("R3 flag pending before combo", rd_data[3], 1);
    wr(word(1, 0, 1, 0));
    check("R7 irq low after enable+clear", irq, 0);
    check("R7 readback ie=1 flag=0", rd_data, 5'b10100);
  endtask

  task automatic t_collision();
    wr(word(0, 0, 0, 0));
    tick = 1'b1;
    repeat (3) step();
    wr(word(0, 1, 0, 0));
    check("R8 clear beats overflow", rd_data[3], 0);
    repeat (3) step();
    check("R8 counter restarted, no early flag", rd_data[3], 0);
    step();
    check("R1 flag after 4 ticks from clear", rd_data[3], 1);
    repeat (3) step();
    wr(word(1, 0, 0, 0));
    check("R9 hw set beats sw clear", rd_data[3], 1);
    tick = 1'b0;
  endtask

  task automatic t_interval(input int sel);
    int period = 1 << (TB + TS * sel + 1);
    int n = 0;
    wr(word(0, 0, 0, sel));
    tick = 1'b1;
    for (int i = 0; i < 1000 && rd_data[3] == 1'b0; i++) begin
      step();
      n++;
    end
    tick = 1'b0;
    check($sformatf("R2 interval sel=%0d", sel), n, period);
  endtask

  task automatic t_gated();
    int period = 1 << (TB + TS + 1);
    int n = 0;
    wr(word(0, 0, 0, 1));
    for (int i = 1; i < 1000 && rd_data[3] == 1'b0; i++) begin
      tick = i[0];
      step();
      n++;
    end
    tick = 1'b0;
    check("R1 gated ticks", n, 2 * period - 1);
    check("R10 strobe reads one", rd_data[4], 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_no_ie();
    t_wake();
    t_clear_flag();
    t_combo();
    t_collision();
    for (int s = 0; s < 4; s++) t_interval(s);
    t_gated();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule